// File: doc/BRIEF.md
# Same-Cycle Bypass Register File

This block is the architectural register file of an in-order five-stage pipeline. It stores 32 general registers of 32 bits. It has two combinational read ports that serve the decode stage and one write port that serves the writeback stage. The write port commits on the rising clock edge.

When writeback and decode touch the same register in the same cycle, the read port returns the value that is being written in that cycle, not the stale stored value. A register file that writes in the first half of the cycle and reads in the second behaves the same way. Because of this, decode never needs a separate forwarding path from writeback, and both stages can use the file in every cycle without a structural conflict.

Register 0 is a constant zero. Writes to it are dropped, and it never takes part in a bypass. A synchronous reset clears every register.

Top module: `bypass_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, every register is cleared, so after reset every read port returns 0 for every address until that register is written.
- R2: When `wr_en` is high at a rising edge, `rst` is low and `wr_addr` is not 0, the register at `wr_addr` takes `wr_data`. From the next cycle on, a read of that address returns it.
- R3: When `wr_en` is low, no register changes, whatever `wr_addr` and `wr_data` carry.
- R4: While `wr_en` is high, `rst` is low and `wr_addr` is nonzero and equal to a read address, that read port returns `wr_data` in the same cycle.
- R5: Address 0 always reads as 0 on both ports. A write to address 0 changes nothing and is never bypassed.
- R6: The two read ports are independent. Each returns the value for its own address in the same cycle, including when one port is bypassed and the other is not.
- R7: A write presented while `rst` is high is discarded and is not bypassed to either read port.
- R8: A read of an address other than the one being written returns the stored value, unaffected by the write in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr_a | input | 5 | Read port A register index |
| rd_addr_b | input | 5 | Read port B register index |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write register index |
| wr_data | input | 32 | Data to write |
| rd_data_a | output | 32 | Read port A data (combinational) |
| rd_data_b | output | 32 | Read port B data (combinational) |

## Verification
The hardest case to reach from the ports is a cycle in which a write and a read share a nonzero address while the other port reads a register that holds a different, previously written value. This cycle also has to be compared with ones where the same address appears with the enable low, with reset high, or with address 0.

The directed phase sets up each of these coincidences on purpose. The random phase draws most addresses from a small pool of low indices, so that write/read address matches and address-0 traffic happen many times.

A behavioural model, updated at each edge, supplies the expected value of both ports in every cycle.

// File: rtl/bypass_regfile_pkg.sv
package bypass_regfile_pkg;
    localparam int unsigned RF_ADDR_W     = 5;
    localparam int unsigned RF_DATA_W     = 32;
    localparam int unsigned RF_READ_PORTS = 2;
endpackage

// File: rtl/rf_write_gate.sv
module rf_write_gate #(
    parameter int unsigned ADDR_W = bypass_regfile_pkg::RF_ADDR_W
) (
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              wr_live
);
    // A write is real only outside reset and never to the zero register.
    always_comb begin
        wr_live = wr_en && !rst && (wr_addr != '0);
    end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int unsigned ADDR_W = bypass_regfile_pkg::RF_ADDR_W,
    parameter int unsigned DATA_W = bypass_regfile_pkg::RF_DATA_W
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  wr_live,
    input  logic [ADDR_W-1:0]                     wr_addr,
    input  logic [DATA_W-1:0]                     wr_data,
    output logic [(1<<ADDR_W)-1:0][DATA_W-1:0]    regs
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] cells;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cells = '0;
        end else if (wr_live) begin
            st_d.cells[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign regs = st_q.cells;
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int unsigned ADDR_W = bypass_regfile_pkg::RF_ADDR_W,
    parameter int unsigned DATA_W = bypass_regfile_pkg::RF_DATA_W
) (
    input  logic [ADDR_W-1:0]                  rd_addr,
    input  logic                               wr_live,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [DATA_W-1:0]                  wr_data,
    input  logic [(1<<ADDR_W)-1:0][DATA_W-1:0] regs,
    output logic [DATA_W-1:0]                  rd_data
);
    logic is_zero;
    logic hit;

    always_comb begin
        is_zero = (rd_addr == '0);
        hit     = wr_live && (wr_addr == rd_addr);
        if (is_zero) begin
            rd_data = '0;
        end else if (hit) begin
            rd_data = wr_data;
        end else begin
            rd_data = regs[rd_addr];
        end
    end
endmodule

// File: rtl/bypass_regfile.sv
module bypass_regfile #(
    parameter int unsigned ADDR_W = bypass_regfile_pkg::RF_ADDR_W,
    parameter int unsigned DATA_W = bypass_regfile_pkg::RF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned NRD   = bypass_regfile_pkg::RF_READ_PORTS;

    logic                         wr_live;
    logic [DEPTH-1:0][DATA_W-1:0] regs;
    logic [NRD-1:0][ADDR_W-1:0]   rd_addr_v;
    logic [NRD-1:0][DATA_W-1:0]   rd_data_v;

    assign rd_addr_v[0] = rd_addr_a;
    assign rd_addr_v[1] = rd_addr_b;
    assign rd_data_a    = rd_data_v[0];
    assign rd_data_b    = rd_data_v[1];

    rf_write_gate #(.ADDR_W(ADDR_W)) i_gate (
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_live (wr_live)
    );

    rf_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
        .clk     (clk),
        .rst     (rst),
        .wr_live (wr_live),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs    (regs)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        rf_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_port (
            .rd_addr (rd_addr_v[p]),
            .wr_live (wr_live),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .regs    (regs),
            .rd_data (rd_data_v[p])
        );
    end
endmodule

// File: rtl/bypass_regfile_chk.sv
module bypass_regfile_chk #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] rd_addr_a,
    input logic [ADDR_W-1:0] rd_addr_b,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [DATA_W-1:0] rd_data_b
);
    p_zero_a_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a == '0) |-> (rd_data_a == '0));

    p_zero_b_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_b == '0) |-> (rd_data_b == '0));

    p_bypass_a_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != '0 && wr_addr == rd_addr_a) |-> (rd_data_a == wr_data));

    p_bypass_b_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != '0 && wr_addr == rd_addr_b) |-> (rd_data_b == wr_data));

    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != '0) |=>
        ((rd_addr_a == $past(wr_addr)) && !(wr_en && wr_addr == rd_addr_a))
        |-> (rd_data_a == $past(wr_data)));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && rd_addr_a == $past(rd_addr_a)
         && !($past(wr_en) && $past(wr_addr) == rd_addr_a)
         && !(wr_en && wr_addr == rd_addr_a))
        |-> $stable(rd_data_a));
endmodule

bind bypass_regfile bypass_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_addr_a (rd_addr_a),
    .rd_addr_b (rd_addr_b),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b)
);

// File: tb/test_bypass_regfile.sv
`timescale 1ns/1ps
module test_bypass_regfile;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data_a, rd_data_b;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [32];

    always #10 clk = ~clk;

    bypass_regfile i_bypass_regfile (
        .clk(clk), .rst(rst),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
    );

    function automatic logic [31:0] expect_rd(input logic [4:0] a);
        if (a == 5'd0) return 32'd0;
        if (!rst && wr_en && wr_addr == a) return wr_data;
        return model[a];
    endfunction

    task automatic compare(input string tag, input string port,
                           input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s port %s: got %h expected %h", tag, port, got, exp);
        end
    endtask

    task automatic cyc(input logic r, input logic we, input logic [4:0] wa,
                       input logic [31:0] wd, input logic [4:0] ra,
                       input logic [4:0] rb, input string tag, input bit chk);
        rst = r; wr_en = we; wr_addr = wa; wr_data = wd;
        rd_addr_a = ra; rd_addr_b = rb;
        @(negedge clk);
        if (chk) begin
            compare(tag, "A", rd_data_a, expect_rd(ra));
            compare(tag, "B", rd_data_b, expect_rd(rb));
        end
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < 32; i++) model[i] = 32'd0;
        end else if (we && wa != 5'd0) begin
            model[wa] = wd;
        end
        #1;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 32'd0;
        cyc(1, 0, 0, 0, 0, 0, "R1", 0);
        cyc(1, 0, 0, 0, 0, 0, "R1", 0);
        // R1: every register reads zero after reset
        for (int i = 0; i < 32; i += 2) cyc(0, 0, 0, 0, 5'(i), 5'(i+1), "R1", 1);
        // R2: fill registers, reading neighbours (R8)
        for (int i = 1; i < 32; i++)
            cyc(0, 1, 5'(i), 32'hA500_0000 + i * 32'h0101, 5'(i-1), 5'((i+5) % 32), "R8", 1);
        for (int i = 0; i < 32; i += 2) cyc(0, 0, 0, 0, 5'(i), 5'(i+1), "R2", 1);
        // R3: enable low with junk address and data
        cyc(0, 0, 5'd7, 32'hDEAD_BEEF, 5'd7, 5'd7, "R3", 1);
        cyc(0, 0, 5'd7, 32'hDEAD_BEEF, 5'd7, 5'd9, "R3", 1);
        // R4: same-cycle bypass on both ports, then on one port (R6)
        cyc(0, 1, 5'd12, 32'h1234_5678, 5'd12, 5'd12, "R4", 1);
        cyc(0, 1, 5'd12, 32'h8765_4321, 5'd12, 5'd13, "R6", 1);
        cyc(0, 1, 5'd20, 32'h0F0F_0F0F, 5'd19, 5'd20, "R6", 1);
        cyc(0, 0, 0, 0, 5'd12, 5'd20, "R2", 1);
        // R5: writes to register zero
        cyc(0, 1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0, "R5", 1);
        cyc(0, 0, 0, 0, 5'd0, 5'd1, "R5", 1);
        // R7: write during reset neither bypassed nor stored
        cyc(1, 1, 5'd5, 32'hCAFE_F00D, 5'd5, 5'd6, "R7", 1);
        cyc(0, 0, 0, 0, 5'd5, 5'd6, "R7", 1);
        cyc(0, 0, 0, 0, 5'd12, 5'd31, "R1", 1);
        // random traffic with frequent address collisions
        for (int n = 0; n < 600; n++) begin
            logic [4:0] wa, ra, rb;
            wa = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'($urandom_range(0, 4));
            ra = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'($urandom_range(0, 4));
            rb = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'($urandom_range(0, 4));
            cyc(($urandom_range(0, 99) == 0), 1'($urandom), wa, $urandom, ra, rb, "R6", 1);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule